// File: doc/BRIEF.md
# Dual Three-Pole Switch Controller with Thermal and Supply Guards

This block turns a two-bit select code per channel into the open/closed states of three analog poles (A, B, C) for each of two independent channels. A shared hold input freezes the selections that are already stored. The stored selection is the channel's state machine state. A separate output register turns that state into pole drives.

Two safety guards override the poles. The first is a thermal guard. It compares a digital die-temperature code with a fixed trip point and a programmable release margin. While it is tripped, it pulls an open-drain shutdown line low. That line is shared, and any other device on it may also pull it low. While the line is low, every pole is open. The stored selections are left as they are, so the poles come back when the line is released. The second is a supply guard. It compares a digital supply-voltage code against separate entry and exit levels. While it is in lockout, every pole is open and the stored selections are wiped to all-off.

Select, hold and the sensed shutdown line each pass through a two-stage synchronizer. The temperature and voltage codes are taken to be already synchronous.

Top module: `dual_switch_ctrl`

States and transitions:
- **Channel** (one per channel): SW_OFF, SW_BC, SW_AB, SW_C.
  - With hold low, each clock loads the state named by the synchronized select code.
  - With hold high, the state stays where it is.
  - Lockout forces SW_OFF.
- **Supply guard**: UV_LOCKED, UV_RUN.
  - UV_LOCKED to UV_RUN when the code is at or above the exit level.
  - UV_RUN to UV_LOCKED when the code is at or below the entry level.
- **Thermal guard**: TH_NORMAL, TH_SHUTDOWN.
  - TH_NORMAL to TH_SHUTDOWN when the temperature is at or above the trip point.
  - TH_SHUTDOWN to TH_NORMAL when the temperature is at or below the trip point minus the clamped margin.

## Requirements
- R1: Each channel's pole vector is {C,B,A} (bit 0 = A). Select code 00 gives 3'b000 and code 01 gives 3'b110 (B and C closed).
- R2: Select code 10 gives 3'b011 (A and B closed) and code 11 gives 3'b100 (only C closed).
- R3: While hold is high, a channel keeps its stored state whatever its select inputs do. Once hold drops, the state follows select again.
- R4: The two channels decode independently. Channel 0 uses sel_i[1:0] and poles_o[2:0]; channel 1 uses sel_i[3:2] and poles_o[5:3].
- R5: While the sensed shutdown line is low (including when it is pulled low externally), all poles are open. On release, each channel shows its stored state again; the stored state is never cleared by the line.
- R6: The thermal guard asserts flag_pull_o once temp_code is at or above 125. It deasserts flag_pull_o once temp_code is at or below 125 minus the margin.
- R7: The margin is therm_margin_i clamped into the range 10 to 25.
- R8: While flag_pull_o is high, all poles are open. After it releases, the stored states return.
- R9: Lockout begins when vdd_code is at or below 300 (10 mV units) and ends only when vdd_code is at or above 340. Codes between the two levels keep the present condition.
- R10: Reset and lockout both open all poles and clear both stored states to 00. During reset, flag_pull_o is 0.
- R11: A select change at the pins shows on the poles at the third rising clock edge after it: two synchronizer stages, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | NCH*2 | Select codes, two bits per channel |
| hold_i | input | 1 | Level hold: high freezes the stored states |
| flag_line_i | input | 1 | Sensed level of the shared shutdown line |
| flag_pull_o | output | 1 | 1 = pull the shutdown line low |
| vdd_code_i | input | VDD_W | Supply voltage code, 10 mV per LSB |
| temp_code_i | input | TEMP_W | Die temperature code, 1 °C per LSB |
| therm_margin_i | input | MARG_W | Thermal release margin in °C (clamped) |
| poles_o | output | NCH*3 | Registered pole drives, {C,B,A} per channel |

## Verification
The hardest case to reach from the pins is a change of selection that happens while the poles are forced open. The override and the stored state have to be told apart even though the outputs show nothing of the stored state at that moment.

The stimulus reaches this case in two ways:
- It changes select under the override with hold set, releases the line, and confirms that the pre-override state reappears.
- It raises hold across a lockout and confirms that the state comes back as all-off rather than as the earlier selection.

The bench models the wired-AND line from the block's own pull and an external pull. This lets internal and external shutdown both arrive through the same sensed pin.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        SW_OFF = 2'b00,
        SW_BC  = 2'b01,
        SW_AB  = 2'b10,
        SW_C   = 2'b11
    } sw_state_t;

    typedef enum logic {
        UV_LOCKED = 1'b0,
        UV_RUN    = 1'b1
    } uv_state_t;

    typedef enum logic {
        TH_NORMAL   = 1'b0,
        TH_SHUTDOWN = 1'b1
    } th_state_t;

    // pole vector layout: bit0 = A, bit1 = B, bit2 = C
    function automatic logic [2:0] pole_map(sw_state_t s);
        logic [2:0] p;
        unique case (s)
            SW_OFF:  p = 3'b000;
            SW_BC:   p = 3'b110;
            SW_AB:   p = 3'b011;
            SW_C:    p = 3'b100;
            default: p = 3'b000;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dsc_uv_fsm.sv
module dsc_uv_fsm
    import dsc_pkg::*;
#(
    parameter int VDD_W  = 10,
    parameter int V_FALL = 300,
    parameter int V_RISE = 340
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VDD_W-1:0] vdd_code_i,
    output logic             lockout_o
);
    localparam logic [VDD_W-1:0] FALL_LVL = VDD_W'(V_FALL);
    localparam logic [VDD_W-1:0] RISE_LVL = VDD_W'(V_RISE);

    uv_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UV_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UV_LOCKED: if (vdd_code_i >= RISE_LVL) state_d = UV_RUN;
            UV_RUN:    if (vdd_code_i <= FALL_LVL) state_d = UV_LOCKED;
            default:   state_d = UV_LOCKED;
        endcase
    end

    always_comb begin
        unique case (state_q)
            UV_RUN:  lockout_o = 1'b0;
            default: lockout_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/dsc_therm_fsm.sv
module dsc_therm_fsm
    import dsc_pkg::*;
#(
    parameter int TEMP_W   = 8,
    parameter int MARG_W   = 5,
    parameter int T_ON     = 125,
    parameter int MARG_MIN = 10,
    parameter int MARG_MAX = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_code_i,
    input  logic [MARG_W-1:0] margin_i,
    output logic              shutdown_o
);
    localparam logic [TEMP_W-1:0] TRIP_LVL = TEMP_W'(T_ON);
    localparam logic [MARG_W-1:0] M_LO     = MARG_W'(MARG_MIN);
    localparam logic [MARG_W-1:0] M_HI     = MARG_W'(MARG_MAX);

    th_state_t         state_q, state_d;
    logic [MARG_W-1:0] margin_eff;
    logic [TEMP_W-1:0] release_lvl;

    always_comb begin
        if (margin_i < M_LO)      margin_eff = M_LO;
        else if (margin_i > M_HI) margin_eff = M_HI;
        else                      margin_eff = margin_i;
        release_lvl = TRIP_LVL - TEMP_W'(margin_eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TH_NORMAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TH_NORMAL:   if (temp_code_i >= TRIP_LVL)    state_d = TH_SHUTDOWN;
            TH_SHUTDOWN: if (temp_code_i <= release_lvl) state_d = TH_NORMAL;
            default:     state_d = TH_NORMAL;
        endcase
    end

    always_comb begin
        unique case (state_q)
            TH_SHUTDOWN: shutdown_o = 1'b1;
            default:     shutdown_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dsc_channel.sv
module dsc_channel
    import dsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_i,
    input  logic       hold_i,
    input  logic       clear_i,
    input  logic       force_open_i,
    output logic [1:0] state_o,
    output logic [2:0] poles_o
);
    sw_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (clear_i)      state_d = SW_OFF;
        else if (!hold_i) state_d = sw_state_t'(sel_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SW_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      poles_o <= 3'b000;
        else if (force_open_i || clear_i) poles_o <= 3'b000;
        else                             poles_o <= pole_map(state_d);
    end

    assign state_o = state_q;
endmodule

// File: rtl/dual_switch_ctrl.sv
module dual_switch_ctrl #(
    parameter int NCH      = 2,
    parameter int SYNC_N   = 2,
    parameter int VDD_W    = 10,
    parameter int V_FALL   = 300,
    parameter int V_RISE   = 340,
    parameter int TEMP_W   = 8,
    parameter int MARG_W   = 5,
    parameter int T_ON     = 125,
    parameter int MARG_MIN = 10,
    parameter int MARG_MAX = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*2-1:0]  sel_i,
    input  logic              hold_i,
    input  logic              flag_line_i,
    output logic              flag_pull_o,
    input  logic [VDD_W-1:0]  vdd_code_i,
    input  logic [TEMP_W-1:0] temp_code_i,
    input  logic [MARG_W-1:0] therm_margin_i,
    output logic [NCH*3-1:0]  poles_o
);
    localparam int CTRL_W = NCH*2 + 2;

    logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
    logic [NCH*2-1:0]  sel_s;
    logic              hold_s;
    logic              flag_s;
    logic              uv_lock;
    logic              th_shut;
    logic              force_open;
    logic [NCH*2-1:0]  held_flat;

    assign ctrl_raw = {flag_line_i, hold_i, sel_i};

    dsc_sync #(
        .W       (CTRL_W),
        .STAGES  (SYNC_N),
        .RST_VAL ({1'b1, {(CTRL_W-1){1'b0}}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ctrl_raw),
        .q_o   (ctrl_s)
    );

    assign sel_s  = ctrl_s[NCH*2-1:0];
    assign hold_s = ctrl_s[NCH*2];
    assign flag_s = ctrl_s[NCH*2+1];

    dsc_uv_fsm #(
        .VDD_W  (VDD_W),
        .V_FALL (V_FALL),
        .V_RISE (V_RISE)
    ) u_uv (
        .clk        (clk),
        .rst_n      (rst_n),
        .vdd_code_i (vdd_code_i),
        .lockout_o  (uv_lock)
    );

    dsc_therm_fsm #(
        .TEMP_W   (TEMP_W),
        .MARG_W   (MARG_W),
        .T_ON     (T_ON),
        .MARG_MIN (MARG_MIN),
        .MARG_MAX (MARG_MAX)
    ) u_therm (
        .clk         (clk),
        .rst_n       (rst_n),
        .temp_code_i (temp_code_i),
        .margin_i    (therm_margin_i),
        .shutdown_o  (th_shut)
    );

    assign flag_pull_o = th_shut;
    assign force_open  = th_shut | ~flag_s;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dsc_channel u_ch (
            .clk          (clk),
            .rst_n        (rst_n),
            .sel_i        (sel_s[c*2 +: 2]),
            .hold_i       (hold_s),
            .clear_i      (uv_lock),
            .force_open_i (force_open),
            .state_o      (held_flat[c*2 +: 2]),
            .poles_o      (poles_o[c*3 +: 3])
        );
    end
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
    parameter int NCH    = 2,
    parameter int VDD_W  = 10,
    parameter int V_FALL = 300,
    parameter int V_RISE = 340,
    parameter int TEMP_W = 8,
    parameter int T_ON   = 125
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH*3-1:0]  poles,
    input logic [NCH*2-1:0]  held,
    input logic              hold_s,
    input logic              flag_s,
    input logic              uv_lock,
    input logic              flag_pull,
    input logic [VDD_W-1:0]  vdd_code,
    input logic [TEMP_W-1:0] temp_code
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        AST_POLES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            poles[c*3 +: 3] inside {3'b000, 3'b110, 3'b011, 3'b100}); // R1
        AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_s && !uv_lock) |=> held[c*2 +: 2] == $past(held[c*2 +: 2])); // R3
        AST_LOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            uv_lock |=> held[c*2 +: 2] == 2'b00); // R10
    end

    AST_LOCK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        uv_lock |=> poles == '0); // R10
    AST_LINE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_s |=> poles == '0); // R5
    AST_PULL_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_pull |=> poles == '0); // R8
    AST_TRIP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_code >= TEMP_W'(T_ON)) |=> flag_pull); // R6
    AST_UV_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (vdd_code <= VDD_W'(V_FALL)) |=> uv_lock); // R9
    AST_UV_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_lock && vdd_code < VDD_W'(V_RISE)) |=> uv_lock); // R9
endmodule

bind dual_switch_ctrl dsc_checker #(
    .NCH    (NCH),
    .VDD_W  (VDD_W),
    .V_FALL (V_FALL),
    .V_RISE (V_RISE),
    .TEMP_W (TEMP_W),
    .T_ON   (T_ON)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .poles     (poles_o),
    .held      (held_flat),
    .hold_s    (hold_s),
    .flag_s    (flag_s),
    .uv_lock   (uv_lock),
    .flag_pull (flag_pull_o),
    .vdd_code  (vdd_code_i),
    .temp_code (temp_code_i)
);

// File: tb/sim_dual_switch_ctrl.sv
`timescale 1ns/1ps
module sim_dual_switch_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sel = 4'h0;
    logic       hold = 1'b0;
    logic       ext_pull = 1'b0;
    logic       flag_line;
    logic       pull;
    logic [9:0] vdd = 10'd500;
    logic [7:0] temp = 8'd25;
    logic [4:0] marg = 5'd15;
    logic [5:0] poles;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        logic [5:0] poles;
        logic       pull;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    assign flag_line = ~(pull | ext_pull);

    dual_switch_ctrl u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .sel_i          (sel),
        .hold_i         (hold),
        .flag_line_i    (flag_line),
        .flag_pull_o    (pull),
        .vdd_code_i     (vdd),
        .temp_code_i    (temp),
        .therm_margin_i (marg),
        .poles_o        (poles)
    );

    task automatic compare(string tag, logic [5:0] ep, logic epl);
        n_cmp++;
        if (poles !== ep || pull !== epl) begin
            n_bad++;
            $display("FAIL %s: poles=%b pull=%b expected poles=%b pull=%b",
                     tag, poles, pull, ep, epl);
        end
    endtask

    // monitor: pop and compare away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            compare(it.tag, it.poles, it.pull);
        end
    end

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_out(string tag, logic [2:0] p1, logic [2:0] p0, logic pl);
        exp_t it;
        it.tag = tag; it.poles = {p1, p0}; it.pull = pl;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic step_sel(logic [1:0] s1, logic [1:0] s0, string tag,
                            logic [2:0] p1, logic [2:0] p0, logic pl);
        sel = {s1, s0}; settle(); expect_out(tag, p1, p0, pl);
    endtask

    task automatic step_temp(logic [7:0] t, string tag,
                             logic [2:0] p1, logic [2:0] p0, logic pl);
        temp = t; settle(); expect_out(tag, p1, p0, pl);
    endtask

    task automatic step_vdd(logic [9:0] v, string tag,
                            logic [2:0] p1, logic [2:0] p0);
        vdd = v; settle(); expect_out(tag, p1, p0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_out("R10 reset all-off", 3'b000, 3'b000, 1'b0);
        rst_n = 1'b1;

        step_sel(2'b00, 2'b00, "R1 code 00", 3'b000, 3'b000, 1'b0);
        step_sel(2'b10, 2'b01, "R1 R2 R4 codes 01/10", 3'b011, 3'b110, 1'b0);
        step_sel(2'b01, 2'b11, "R2 R4 codes 11/01", 3'b110, 3'b100, 1'b0);

        hold = 1'b1;
        step_sel(2'b10, 2'b00, "R3 hold keeps state", 3'b110, 3'b100, 1'b0);
        hold = 1'b0; settle();
        expect_out("R3 hold released", 3'b011, 3'b000, 1'b0);

        step_sel(2'b11, 2'b10, "R2 R4 codes 10/11", 3'b100, 3'b011, 1'b0);
        hold = 1'b1;
        ext_pull = 1'b1; settle();
        expect_out("R5 external pull opens", 3'b000, 3'b000, 1'b0);
        step_sel(2'b01, 2'b01, "R5 select under override", 3'b000, 3'b000, 1'b0);
        ext_pull = 1'b0; settle();
        expect_out("R5 release restores held", 3'b100, 3'b011, 1'b0);
        hold = 1'b0; settle();
        expect_out("R3 follow after hold", 3'b110, 3'b110, 1'b0);

        step_temp(8'd125, "R6 R8 trip at 125", 3'b000, 3'b000, 1'b1);
        step_temp(8'd111, "R6 inside margin 15", 3'b000, 3'b000, 1'b1);
        step_temp(8'd110, "R6 R8 release at 110", 3'b110, 3'b110, 1'b0);

        marg = 5'd5;
        step_temp(8'd130, "R7 trip low margin", 3'b000, 3'b000, 1'b1);
        step_temp(8'd116, "R7 margin clamped to 10", 3'b000, 3'b000, 1'b1);
        step_temp(8'd115, "R7 release at 115", 3'b110, 3'b110, 1'b0);
        marg = 5'd31;
        step_temp(8'd126, "R7 trip high margin", 3'b000, 3'b000, 1'b1);
        step_temp(8'd101, "R7 margin clamped to 25", 3'b000, 3'b000, 1'b1);
        step_temp(8'd100, "R7 release at 100", 3'b110, 3'b110, 1'b0);
        temp = 8'd25; marg = 5'd15;

        step_vdd(10'd320, "R9 between levels stays run", 3'b110, 3'b110);
        hold = 1'b1;
        step_vdd(10'd300, "R9 lockout at 300", 3'b000, 3'b000);
        step_vdd(10'd339, "R9 below exit stays locked", 3'b000, 3'b000);
        step_vdd(10'd340, "R10 held cleared by lockout", 3'b000, 3'b000);
        hold = 1'b0; settle();
        expect_out("R10 select resumes", 3'b110, 3'b110, 1'b0);

        // R11 exact latency: new value on third rising edge
        sel = 4'b1111;
        @(negedge clk); @(negedge clk);
        compare("R11 unchanged after two edges", 6'b110110, 1'b0);
        @(negedge clk);
        compare("R11 changed on third edge", 6'b100100, 1'b0);

        while (sb_q.size() > 0) @(negedge clk);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: done=0 expected done=1");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule